// File: doc/BRIEF.md
# Digit-Serial Binary-Field Multiply-Accumulate Unit

This unit computes A·B + C over the binary extension field GF(2^M) in polynomial basis, reducing modulo a field polynomial that is supplied at run time. The polynomial always has degree M. Its leading term x^M is implied, and the port carries only its M lower coefficients. A pulse on `start_i` captures all four operands. The multiplier B is then consumed D bits per clock, lowest digit first. Each cycle, the current digit scales a running copy of A, and that partial product is XORed into an accumulator that was preloaded with C. The running copy of A is then advanced by x^D modulo the polynomial.

A product takes K = ceil(M/D) cycles. When M is not a multiple of D, the top digit of B is padded with zeros. On completion the unit raises `done_o` for one cycle. It also updates `result_o` and `zero_o`, which then hold until the next completion. M and D are parameters. The unit is meant for fields up to 167 bits with digit sizes of 4, 8 or 16. The bench uses a small field.

Top module: `gf_dsmac`

## Requirements
- R1: When `done_o` is high, `result_o` equals (A·B + C) mod (x^M + F), where A, B, C and F are the values of `a_i`, `b_i`, `c_i` and `f_i` at the accepted start. Bit i of each vector is the coefficient of x^i.
- R2: An accepted start at clock edge n makes `done_o` high in the cycle after edge n+K, with K = ceil(M/D). `done_o` is low in every other cycle of that operation, and it is never high for two cycles in a row.
- R3: B is consumed in D-bit digits, least significant first, with the top digit zero-padded when D does not divide M. Coefficients of B in the top, partial digit contribute correctly to the result.
- R4: `zero_o` is 1 exactly when `result_o` is the all-zero field element.
- R5: A `start_i` pulse while an operation is in progress is ignored. The running result is unchanged and no extra `done_o` pulse follows.
- R6: `result_o` and `zero_o` keep their values between completions, whatever the operand inputs do.
- R7: A start asserted in the same cycle that `done_o` is high is accepted. The next result follows K cycles later.
- R8: After reset, `done_o` is 0, `result_o` is 0 and `zero_o` is 1.
- R9: The field polynomial is programmable per operation. Changes on `a_i`, `b_i`, `c_i` or `f_i` after the start have no effect on the running operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation when the unit is idle |
| a_i | input | M | Multiplicand A |
| b_i | input | M | Multiplier B, consumed one digit per cycle |
| c_i | input | M | Addend C |
| f_i | input | M | Low M coefficients of the field polynomial |
| result_o | output | M | Last completed A·B + C mod polynomial |
| done_o | output | 1 | One-cycle completion pulse |
| zero_o | output | 1 | Result is the zero element |

## Verification
The completion of one product and the acceptance of the next can fall in the same cycle. The idle test on the next edge sees that the finishing operation has just cleared its busy state. The bench provokes this by driving `start_i` with fresh operands in the very cycle it observes `done_o` high. It then checks two things: that the first result is presented intact in that cycle, and that the second result arrives exactly K cycles later with the correct value. A second overlap is also tested: a start that arrives while a product is still running. That start must be dropped, which the bench judges by the original result and by the absence of a second pulse.

// File: rtl/gf_dsmac_pkg.sv
package gf_dsmac_pkg;

    // ceil(x / y) for positive integers
    function automatic int cdiv(input int x, input int y);
        return (x + y - 1) / y;
    endfunction

    // width of a counter that must hold values 0 .. n-1
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/gf_xtime.sv
// Multiply a field element by x and reduce modulo x^M + f.
module gf_xtime #(
    parameter int M = 167
) (
    input  logic [M-1:0] v_i,
    input  logic [M-1:0] f_i,
    output logic [M-1:0] y_o
);
    always_comb begin
        y_o = {v_i[M-2:0], 1'b0};
        if (v_i[M-1]) begin
            y_o = y_o ^ f_i;
        end
    end
endmodule

// File: rtl/gf_digit_step.sv
// One digit step: acc ^= digit * a, and a *= x^D, both reduced modulo the field polynomial.
module gf_digit_step #(
    parameter int M = 167,
    parameter int D = 8
) (
    input  logic [M-1:0] acc_i,
    input  logic [M-1:0] a_i,
    input  logic [D-1:0] dig_i,
    input  logic [M-1:0] f_i,
    output logic [M-1:0] acc_o,
    output logic [M-1:0] a_o
);
    logic [M-1:0] a_chain   [D+1];
    logic [M-1:0] acc_chain [D+1];

    assign a_chain[0]   = a_i;
    assign acc_chain[0] = acc_i;

    for (genvar g = 0; g < D; g++) begin : g_bit
        assign acc_chain[g+1] = acc_chain[g] ^ (dig_i[g] ? a_chain[g] : '0);
        gf_xtime #(.M(M)) u_xt (
            .v_i (a_chain[g]),
            .f_i (f_i),
            .y_o (a_chain[g+1])
        );
    end

    assign acc_o = acc_chain[D];
    assign a_o   = a_chain[D];
endmodule

// File: rtl/gf_dsmac.sv
module gf_dsmac
    import gf_dsmac_pkg::*;
#(
    parameter int M = 167,
    parameter int D = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [M-1:0] a_i,
    input  logic [M-1:0] b_i,
    input  logic [M-1:0] c_i,
    input  logic [M-1:0] f_i,
    output logic [M-1:0] result_o,
    output logic         done_o,
    output logic         zero_o
);
    localparam int K  = cdiv(M, D);
    localparam int BW = K * D;
    localparam int CW = cnt_width(K);
    localparam logic [CW-1:0] LAST = CW'(K - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [M-1:0]  a;
        logic [BW-1:0] b;
        logic [M-1:0]  acc;
        logic [M-1:0]  f;
        logic [M-1:0]  res;
        logic          zero;
        logic          done;
    } state_t;

    state_t s_d, s_q;
    logic [M-1:0] step_acc, step_a;

    gf_digit_step #(.M(M), .D(D)) u_step (
        .acc_i (s_q.acc),
        .a_i   (s_q.a),
        .dig_i (s_q.b[D-1:0]),
        .f_i   (s_q.f),
        .acc_o (step_acc),
        .a_o   (step_a)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start_i) begin
                s_d.busy       = 1'b1;
                s_d.cnt        = '0;
                s_d.a          = a_i;
                s_d.b          = '0;
                s_d.b[M-1:0]   = b_i;
                s_d.acc        = c_i;
                s_d.f          = f_i;
            end
        end else begin
            s_d.acc = step_acc;
            s_d.a   = step_a;
            s_d.b   = s_q.b >> D;
            s_d.cnt = s_q.cnt + CW'(1);
            if (s_q.cnt == LAST) begin
                s_d.busy = 1'b0;
                s_d.cnt  = '0;
                s_d.res  = step_acc;
                s_d.zero = (step_acc == '0);
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.zero <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign result_o = s_q.res;
    assign done_o   = s_q.done;
    assign zero_o   = s_q.zero;

    // R2: completion is a single-cycle pulse
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2: the last digit is followed by done
    a_r2_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.cnt == LAST) |=> done_o);

    // R2: no done before the last digit
    a_r2_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.cnt != LAST) |=> !done_o);

    // R4: zero flag agrees with the presented result
    a_r4_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (zero_o == (result_o == '0)));

    // R6: outputs only move on a completion
    a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(result_o) && $stable(zero_o)));

    // R5 / R9: a running operation keeps its captured polynomial
    a_r5_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.cnt != LAST && start_i) |=> (s_q.busy && s_q.f == $past(s_q.f)));
endmodule

// File: tb/gf_dsmac_tb_top.sv
module gf_dsmac_tb_top;
    localparam int BM = 11;
    localparam int BD = 4;
    localparam int K  = (BM + BD - 1) / BD;
    localparam int NV = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [BM-1:0] a_i = '0, b_i = '0, c_i = '0, f_i = '0;
    logic [BM-1:0] result_o;
    logic          done_o, zero_o;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    gf_dsmac #(.M(BM), .D(BD)) dut_i (
        .clk, .rst_n, .start_i, .a_i, .b_i, .c_i, .f_i,
        .result_o, .done_o, .zero_o
    );

    // {a, b, c, f}
    localparam logic [4*BM-1:0] VEC [NV] = '{
        {11'h001, 11'h7FF, 11'h000, 11'h005},
        {11'h7FF, 11'h001, 11'h000, 11'h005},
        {11'h123, 11'h456, 11'h789, 11'h005},
        {11'h400, 11'h400, 11'h000, 11'h005},
        {11'h5A5, 11'h3C3, 11'h7FF, 11'h0A1},
        {11'h7FF, 11'h7FF, 11'h2AA, 11'h0A1},
        {11'h000, 11'h6B1, 11'h155, 11'h005},
        {11'h321, 11'h000, 11'h000, 11'h0A1}
    };

    // schoolbook carry-less product followed by long division
    function automatic logic [BM-1:0] ref_mac(input logic [BM-1:0] a, b, c, f);
        logic [2*BM-2:0] p;
        logic [2*BM-2:0] poly;
        p = '0;
        for (int i = 0; i < BM; i++)
            if (b[i]) p = p ^ ((2*BM-1)'(a) << i);
        poly = (2*BM-1)'({1'b1, f});
        for (int k = 2*BM-2; k >= BM; k--)
            if (p[k]) p = p ^ (poly << (k - BM));
        return p[BM-1:0] ^ c;
    endfunction

    task automatic check(input bit ok, input string req, input logic [BM-1:0] act, exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic launch(input logic [BM-1:0] a, b, c, f);
        a_i = a; b_i = b; c_i = c; f_i = f;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // waits until the cycle done should appear; checks no early done
    task automatic expect_done(input int elapsed, input string req);
        bit early = 1'b0;
        for (int i = elapsed; i < K; i++) begin
            if (done_o) early = 1'b1;
            @(negedge clk);
        end
        check(!early, req, BM'(early), '0);
        check(done_o === 1'b1, req, BM'(done_o), 11'h001);
    endtask

    task automatic check_result(input logic [BM-1:0] exp, input string req);
        check(result_o === exp, req, result_o, exp);
        check(zero_o === (exp == '0), "R4", BM'(zero_o), BM'(exp == '0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog actual=%h expected=%h", 1, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [BM-1:0] e1, e2;
        repeat (3) @(negedge clk);
        // R8 reset state
        check(done_o === 1'b0, "R8", BM'(done_o), '0);
        check(result_o === '0, "R8", result_o, '0);
        check(zero_o === 1'b1, "R8", BM'(zero_o), 11'h001);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R3 / R4 / R2: vector table
        for (int v = 0; v < NV; v++) begin
            logic [BM-1:0] va, vb, vc, vf;
            {va, vb, vc, vf} = VEC[v];
            launch(va, vb, vc, vf);
            expect_done(0, "R2");
            check_result(ref_mac(va, vb, vc, vf), (v == 0 || v == 3) ? "R3" : "R1");
            @(negedge clk);
            check(done_o === 1'b0, "R2", BM'(done_o), '0);
        end

        // R4: A*B cancels C exactly
        e1 = ref_mac(11'h2D3, 11'h19E, 11'h000, 11'h005);
        launch(11'h2D3, 11'h19E, e1, 11'h005);
        expect_done(0, "R2");
        check_result('0, "R4");
        @(negedge clk);

        // R9: operands change after start
        e1 = ref_mac(11'h0F0, 11'h70F, 11'h011, 11'h005);
        launch(11'h0F0, 11'h70F, 11'h011, 11'h005);
        a_i = 11'h7FF; b_i = 11'h555; c_i = 11'h2AA; f_i = 11'h0A1;
        expect_done(0, "R9");
        check_result(e1, "R9");
        @(negedge clk);

        // R6: inputs wiggle with no start; outputs hold
        for (int i = 0; i < 4; i++) begin
            a_i = BM'(i * 37); b_i = BM'(i * 91 + 5); c_i = BM'(i * 13);
            @(negedge clk);
            check(result_o === e1 && done_o === 1'b0, "R6", result_o, e1);
        end

        // R5: start while busy is ignored
        e1 = ref_mac(11'h333, 11'h4C1, 11'h0AB, 11'h0A1);
        launch(11'h333, 11'h4C1, 11'h0AB, 11'h0A1);
        a_i = 11'h001; b_i = 11'h001; c_i = 11'h7FF; f_i = 11'h005;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        expect_done(1, "R5");
        check_result(e1, "R5");
        begin
            bit extra = 1'b0;
            for (int i = 0; i < K + 3; i++) begin
                @(negedge clk);
                if (done_o) extra = 1'b1;
            end
            check(!extra, "R5", BM'(extra), '0);
            check(result_o === e1, "R5", result_o, e1);
        end

        // R7: start in the done cycle
        e1 = ref_mac(11'h1AB, 11'h6CD, 11'h000, 11'h005);
        e2 = ref_mac(11'h7E1, 11'h3F7, 11'h444, 11'h0A1);
        launch(11'h1AB, 11'h6CD, 11'h000, 11'h005);
        expect_done(0, "R7");
        check_result(e1, "R7");
        launch(11'h7E1, 11'h3F7, 11'h444, 11'h0A1);
        expect_done(0, "R7");
        check_result(e2, "R7");
        @(negedge clk);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule